// File: doc/BRIEF.md
# Synthesiser Sub-Band Lock Search Controller

This block sits on the host side of a tuner and brings the frequency synthesiser to lock for one requested channel. A pulse on `start_i` samples the channel frequency in MHz, a precomputed integer divider and a post-divide code. A frequency outside the supported band is rejected at once: the fail flag is set and no register access is made. Otherwise the block first writes the RF input-path selection for the channel's band. It then writes the two divider bytes. After that it starts a search over the combined oscillator/sub-band code, beginning at a mid-range code.

For each candidate code the block writes the oscillator register and waits a parameterised settle time. It then reads the status register and decodes the three-bit tuning-window indicator. A reading inside the window ends the search with lock. A reading at the bottom of the window moves to the next lower code, and a reading at the top moves to the next higher code. The search fails when it would step past either end of the code range, or on a second change of direction. The first code that locks is kept. All register traffic goes over a simple request/acknowledge master port.

Top module: `tune_seq`

## Requirements
- R1: After reset `done_o`, `locked_o`, `fail_o` and `bus_req_o` are low and `vco_code_o` equals MID_CODE (default 16).
- R2: A start with `freq_mhz_i` below 54 or above 860 produces a `done_o` pulse with `fail_o` high and `locked_o` low, and issues no bus transaction.
- R3: The first transaction of an accepted start writes address 0x5 with bits 7:2 zero and bits 1:0 set to the path code: 2'b00 for 54 to 99 MHz, 2'b01 for 100 to 299 MHz, 2'b10 for 300 to 860 MHz.
- R4: The second write goes to address 0x0 with data {1'b0, ndiv[14:8]}, and the third goes to address 0x1 with data ndiv[7:0].
- R5: Each oscillator write goes to address 0x3 with data {code[4:0], 1'b0, vdiv[1:0]}. The first such write of a search uses MID_CODE.
- R6: The status read (read of address 0xC, indicator in bits 6:4) is requested no earlier than SETTLE_CYC full clock cycles after the edge that completed the preceding oscillator write.
- R7: An indicator value from 3'b001 to 3'b110 ends the search with `locked_o` high, `fail_o` low, and `vco_code_o` holding the code last written.
- R8: An indicator of 3'b111 makes the next oscillator write use code+1. An indicator of 3'b000 makes it use code-1.
- R9: An indicator of 3'b111 at code NUM_CODES-1 (default 23), or 3'b000 at code 0, ends the search with `fail_o` high and no further write.
- R10: One change of search direction is tolerated. An indicator that would reverse direction a second time ends the search with `fail_o` high.
- R11: `done_o` is high for exactly one cycle per accepted start. `locked_o` and `fail_o` hold until the next start.
- R12: While `bus_req_o` is high and `bus_ack_i` low, the request and its address, direction and write data stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tune; sampled while idle |
| freq_mhz_i | input | FREQ_W | Channel frequency in MHz |
| ndiv_i | input | 15 | Precomputed integer divider |
| vdiv_i | input | 2 | Post-divide code |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 4 | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Access complete (one cycle) |
| bus_rdata_i | input | 8 | Read data, valid with `bus_ack_i` |
| vco_code_o | output | CODE_W | Current or final oscillator/sub-band code |
| locked_o | output | 1 | Search ended in lock |
| fail_o | output | 1 | Rejected or search failed |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take four things for granted about the bus slave. It acknowledges only while a request is pending. The acknowledge lasts one cycle. Read data is valid in that same cycle. `start_i` is meaningful only while the block is idle. The bench slave raises `bus_ack_i` in the cycle after it first sees a request and then lowers it. It returns the status indicator with that acknowledge. The bench pulses `start_i` only after the previous `done_o` has been seen. The indicator comes either from a window model driven by the code written to address 0x3, or from a short script of readings.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 4;
  localparam int NDIV_W = 15;

  localparam logic [ADDR_W-1:0] ADDR_NHI  = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_NLO  = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_VCO  = 4'h3;
  localparam logic [ADDR_W-1:0] ADDR_PATH = 4'h5;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'hC;

  localparam logic [1:0] PATH_VHF_LP = 2'b00;
  localparam logic [1:0] PATH_VHF    = 2'b01;
  localparam logic [1:0] PATH_UHF    = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_PATH, S_WR_NHI, S_WR_NLO, S_WR_VCO, S_SETTLE, S_RD_LD, S_FINISH
  } tune_state_e;

  typedef enum logic [1:0] {ACT_LOCK, ACT_UP, ACT_DOWN, ACT_FAIL} step_act_e;
endpackage

// File: rtl/band_sel.sv
module band_sel import tune_pkg::*; #(
  parameter int FREQ_W  = 10,
  parameter int F_MIN   = 54,
  parameter int F_MID_A = 100,
  parameter int F_MID_B = 300,
  parameter int F_MAX   = 860
) (
  input  logic [FREQ_W-1:0] freq_i,
  output logic              in_range_o,
  output logic [1:0]        path_o
);
  localparam logic [FREQ_W-1:0] LO_F = FREQ_W'(F_MIN);
  localparam logic [FREQ_W-1:0] A_F  = FREQ_W'(F_MID_A);
  localparam logic [FREQ_W-1:0] B_F  = FREQ_W'(F_MID_B);
  localparam logic [FREQ_W-1:0] HI_F = FREQ_W'(F_MAX);

  always_comb begin
    in_range_o = (freq_i >= LO_F) && (freq_i <= HI_F);
    if (freq_i < A_F)      path_o = PATH_VHF_LP;
    else if (freq_i < B_F) path_o = PATH_VHF;
    else                   path_o = PATH_UHF;
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (run_i && !expired_o)     cnt_q <= cnt_q + 1'b1;
  end

  AST_SETTLE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i && !expired_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
endmodule

// File: rtl/code_stepper.sv
module code_stepper import tune_pkg::*; #(
  parameter int CODE_W    = 5,
  parameter int NUM_CODES = 24,
  parameter int MID_CODE  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              eval_i,
  input  logic [2:0]        ld_i,
  output logic [CODE_W-1:0] code_o,
  output step_act_e         act_o
);
  localparam logic [CODE_W-1:0] TOP_C = CODE_W'(NUM_CODES - 1);
  localparam logic [CODE_W-1:0] MID_C = CODE_W'(MID_CODE);

  logic [CODE_W-1:0] code_q;
  logic dir_valid_q, dir_up_q, rev_q;
  logic go_up, rev_now;

  assign code_o = code_q;

  always_comb begin
    go_up   = (ld_i == 3'b111);
    rev_now = dir_valid_q && (dir_up_q != go_up);
    if (ld_i != 3'b000 && ld_i != 3'b111)                 act_o = ACT_LOCK;
    else if ((go_up && code_q == TOP_C) ||
             (!go_up && code_q == '0) ||
             (rev_now && rev_q))                          act_o = ACT_FAIL;
    else if (go_up)                                       act_o = ACT_UP;
    else                                                  act_o = ACT_DOWN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q      <= MID_C;
      dir_valid_q <= 1'b0;
      dir_up_q    <= 1'b0;
      rev_q       <= 1'b0;
    end else if (init_i) begin
      code_q      <= MID_C;
      dir_valid_q <= 1'b0;
      dir_up_q    <= 1'b0;
      rev_q       <= 1'b0;
    end else if (eval_i && (act_o == ACT_UP || act_o == ACT_DOWN)) begin
      code_q      <= go_up ? code_q + 1'b1 : code_q - 1'b1;
      dir_valid_q <= 1'b1;
      dir_up_q    <= go_up;
      if (rev_now) rev_q <= 1'b1;
    end
  end

  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !init_i && act_o == ACT_UP) |=> (code_q == $past(code_q) + 1'b1)); // R8
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !init_i && act_o == ACT_DOWN) |=> (code_q == $past(code_q) - 1'b1)); // R8
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= TOP_C); // R9
  AST_REV_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && rev_q && rev_now && ld_i inside {3'b000, 3'b111}) |-> (act_o == ACT_FAIL)); // R10
endmodule

// File: rtl/tune_seq.sv
module tune_seq import tune_pkg::*; #(
  parameter int FREQ_W     = 10,
  parameter int CODE_W     = 5,
  parameter int NUM_CODES  = 24,
  parameter int MID_CODE   = 16,
  parameter int SETTLE_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_mhz_i,
  input  logic [14:0]       ndiv_i,
  input  logic [1:0]        vdiv_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [3:0]        bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [7:0]        bus_rdata_i,
  output logic [CODE_W-1:0] vco_code_o,
  output logic              locked_o,
  output logic              fail_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] MID_C = CODE_W'(MID_CODE);

  tune_state_e state_q, state_d;
  logic [NDIV_W-1:0] ndiv_q;
  logic [1:0]        vdiv_q, path_q;
  logic              locked_q, fail_q;
  logic              in_range, accept, eval, expired;
  logic [1:0]        path;
  step_act_e         act;
  logic              unused_rdata;

  assign unused_rdata = ^{bus_rdata_i[7], bus_rdata_i[3:0]};
  assign accept = (state_q == S_IDLE) && start_i;
  assign eval   = (state_q == S_RD_LD) && bus_ack_i;

  band_sel #(.FREQ_W(FREQ_W)) i_band (
    .freq_i(freq_mhz_i), .in_range_o(in_range), .path_o(path)
  );

  code_stepper #(.CODE_W(CODE_W), .NUM_CODES(NUM_CODES), .MID_CODE(MID_CODE)) i_step (
    .clk_i, .rst_ni, .init_i(accept), .eval_i(eval),
    .ld_i(bus_rdata_i[6:4]), .code_o(vco_code_o), .act_o(act)
  );

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk_i, .rst_ni, .clear_i(state_q != S_SETTLE),
    .run_i(state_q == S_SETTLE), .expired_o(expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = in_range ? S_WR_PATH : S_FINISH;
      S_WR_PATH: if (bus_ack_i) state_d = S_WR_NHI;
      S_WR_NHI:  if (bus_ack_i) state_d = S_WR_NLO;
      S_WR_NLO:  if (bus_ack_i) state_d = S_WR_VCO;
      S_WR_VCO:  if (bus_ack_i) state_d = S_SETTLE;
      S_SETTLE:  if (expired) state_d = S_RD_LD;
      S_RD_LD:   if (bus_ack_i)
                   state_d = (act == ACT_UP || act == ACT_DOWN) ? S_WR_VCO : S_FINISH;
      S_FINISH:  state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ndiv_q   <= '0;
      vdiv_q   <= '0;
      path_q   <= '0;
      locked_q <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ndiv_q   <= ndiv_i;
        vdiv_q   <= vdiv_i;
        path_q   <= path;
        locked_q <= 1'b0;
        fail_q   <= !in_range;
      end else if (eval) begin
        if (act == ACT_LOCK) locked_q <= 1'b1;
        if (act == ACT_FAIL) fail_q   <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b1;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      S_WR_PATH: begin bus_addr_o = ADDR_PATH; bus_wdata_o = {6'b0, path_q};        end
      S_WR_NHI:  begin bus_addr_o = ADDR_NHI;  bus_wdata_o = {1'b0, ndiv_q[14:8]};  end
      S_WR_NLO:  begin bus_addr_o = ADDR_NLO;  bus_wdata_o = ndiv_q[7:0];           end
      S_WR_VCO:  begin bus_addr_o = ADDR_VCO;  bus_wdata_o = {vco_code_o[4:0], 1'b0, vdiv_q}; end
      S_RD_LD:   begin bus_addr_o = ADDR_STAT; bus_we_o = 1'b0;                     end
      default:   begin bus_req_o = 1'b0; bus_we_o = 1'b0;                           end
    endcase
  end

  assign locked_o = locked_q;
  assign fail_o   = fail_q;
  assign done_o   = (state_q == S_FINISH);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o))); // R12
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(locked_o && fail_o)); // R7
  AST_REJECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_range) |=> (done_o && fail_o && !bus_req_o)); // R2
  AST_SEARCH_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_range) |=> (vco_code_o == MID_C)); // R5
endmodule

// File: tb/test_tune_seq.sv
module test_tune_seq;
  localparam int S = 6;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [9:0] freq = '0;
  logic [14:0] ndiv = '0;
  logic [1:0] vdiv = '0;
  logic req, we, ack, done, locked, fail;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [4:0] code;

  int vectors = 0, errors = 0;
  int cyc = 0, last_vco_cyc = 0, min_gap = 0;
  int log_n = 0;
  int log_addr [64];
  int log_we   [64];
  int log_data [64];
  logic [7:0] regs [16];
  int mode = 0, win_lo = 0, win_hi = 23, rd_idx = 0;
  logic [2:0] script [4];
  bit finished = 0;

  always #5 clk = ~clk;

  tune_seq #(.SETTLE_CYC(S)) i_tune_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_mhz_i(freq),
    .ndiv_i(ndiv), .vdiv_i(vdiv), .bus_req_o(req), .bus_we_o(we),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_ack_i(ack), .bus_rdata_i(rdata),
    .vco_code_o(code), .locked_o(locked), .fail_o(fail), .done_o(done)
  );

  function automatic logic [2:0] ld_of(input int c);
    if (c < win_lo) return 3'b111;
    if (c > win_hi) return 3'b000;
    return 3'b011;
  endfunction

  // bus slave: ack one cycle after request, indicator from window or script
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 0; rdata <= '0;
    end else begin
      cyc <= cyc + 1;
      if (req && ack) begin
        if (log_n < 64) begin
          log_addr[log_n] = int'(addr); log_we[log_n] = int'(we); log_data[log_n] = int'(wdata);
        end
        log_n <= log_n + 1;
        if (we) regs[addr] <= wdata;
        if (we && addr == 4'h3) last_vco_cyc <= cyc;
      end
      if (req && !ack) begin
        ack <= 1;
        if (!we && addr == 4'hC) begin
          if (cyc - last_vco_cyc < min_gap) min_gap <= cyc - last_vco_cyc;
          if (mode == 0) rdata <= {1'b0, ld_of(int'(regs[3][7:3])), 4'h0};
          else begin
            rdata <= {1'b0, script[rd_idx], 4'h0};
            rd_idx <= (rd_idx < 3) ? rd_idx + 1 : rd_idx;
          end
        end
      end else ack <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int vco_writes();
    int n = 0;
    for (int i = 0; i < log_n && i < 64; i++)
      if (log_we[i] == 1 && log_addr[i] == 3) n++;
    return n;
  endfunction

  task automatic run_tune(input int f, input int n, input int v);
    int t = 0;
    @(negedge clk);
    freq = 10'(f); ndiv = 15'(n); vdiv = 2'(v);
    log_n = 0; min_gap = 1000000; rd_idx = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(done, "R11 done seen", int'(done), 1);
    @(negedge clk);
    chk(!done, "R11 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk(!done && !locked && !fail, "R1 flags after reset", int'({done, locked, fail}), 0);
    chk(!req, "R1 no request", int'(req), 0);
    chk(code == 5'd16, "R1 code", int'(code), 16);
  endtask

  task automatic t_reject(input int f);
    mode = 0; win_lo = 0; win_hi = 23;
    run_tune(f, 4688, 1);
    chk(fail && !locked, "R2 reject flags", int'({locked, fail}), 1);
    chk(log_n == 0, "R2 no transactions", log_n, 0);
  endtask

  task automatic t_band(input int f, input int exp_path, input int n, input int v);
    mode = 0; win_lo = 0; win_hi = 23;
    run_tune(f, n, v);
    chk(log_addr[0] == 5 && log_data[0] == exp_path, "R3 path write", log_data[0], exp_path);
    chk(log_addr[1] == 0 && log_data[1] == (n >> 8), "R4 divider high", log_data[1], n >> 8);
    chk(log_addr[2] == 1 && log_data[2] == (n & 255), "R4 divider low", log_data[2], n & 255);
    chk(log_addr[3] == 3 && log_data[3] == (16 * 8 + v), "R5 first vco write", log_data[3], 16 * 8 + v);
    chk(log_n == 5 && log_we[4] == 0 && log_addr[4] == 12, "R6 single status read", log_n, 5);
    chk(min_gap >= S + 1, "R6 settle gap", min_gap, S + 1);
    chk(locked && !fail && code == 5'd16, "R7 lock at mid", int'(code), 16);
  endtask

  task automatic t_search(input int lo, input int hi, input int exp_code, input int exp_wr);
    mode = 0; win_lo = lo; win_hi = hi;
    run_tune(500, 9000, 2);
    chk(locked && !fail, "R7 locked after search", int'({locked, fail}), 2);
    chk(int'(code) == exp_code, "R8 final code", int'(code), exp_code);
    chk(vco_writes() == exp_wr, "R8 vco write count", vco_writes(), exp_wr);
    chk(log_data[log_n - 2] == exp_code * 8 + 2, "R5 last vco data", log_data[log_n - 2], exp_code * 8 + 2);
    chk(min_gap >= S + 1, "R6 settle gap in search", min_gap, S + 1);
  endtask

  task automatic t_edge_fail(input int lo, input int hi, input int exp_code, input int exp_wr);
    mode = 0; win_lo = lo; win_hi = hi;
    run_tune(700, 9000, 0);
    chk(fail && !locked, "R9 edge fail flags", int'({locked, fail}), 1);
    chk(int'(code) == exp_code, "R9 edge code", int'(code), exp_code);
    chk(vco_writes() == exp_wr, "R9 vco writes", vco_writes(), exp_wr);
    chk(log_we[log_n - 1] == 0, "R9 no write after fail", log_we[log_n - 1], 0);
  endtask

  task automatic t_reverse(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                           input bit exp_lock);
    mode = 1; script[0] = a; script[1] = b; script[2] = c; script[3] = 3'b000;
    run_tune(200, 3000, 3);
    chk(locked == exp_lock && fail == !exp_lock, "R10 reversal outcome", int'({locked, fail}),
        exp_lock ? 2 : 1);
    chk(code == 5'd16, "R10 code after reversals", int'(code), 16);
    chk(vco_writes() == 3, "R10 vco writes", vco_writes(), 3);
  endtask

  task automatic t_hold();
    mode = 0; win_lo = 0; win_hi = 23;
    run_tune(400, 5000, 1);
    repeat (10) @(negedge clk);
    chk(locked && !fail && !req, "R11 flags held", int'({locked, fail}), 2);
    t_reject(861);
    chk(!locked, "R11 lock cleared by start", int'(locked), 0);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reject(53);
    t_reject(861);
    t_band(54, 0, 4688, 1);
    t_band(99, 0, 256, 0);
    t_band(100, 1, 32767, 2);
    t_band(299, 1, 1234, 3);
    t_band(300, 2, 4688, 1);
    t_band(860, 2, 20000, 0);
    t_search(20, 22, 20, 5);
    t_search(3, 5, 5, 12);
    t_edge_fail(30, 31, 23, 8);
    t_edge_fail(0, -1, 0, 17);
    t_reverse(3'b111, 3'b000, 3'b010, 1'b1);
    t_reverse(3'b111, 3'b000, 3'b111, 1'b0);
    t_hold();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule